// File: doc/BRIEF.md
# Serial Divider Configuration Port

This block is the configuration front end of a frequency synthesizer. A host drives three slow wires, a serial clock, a data line and a latch strobe, without any relation to the system clock. Each wire is brought into the system clock domain through a synchronizer. Every rising edge of the serial clock pushes one data bit into an 18-bit shift register, most significant bit first.

The bit shifted in last is the address. On a rising edge of the latch strobe, the shifted word is committed to one of two configuration registers. The reference register holds the reference divide count and the phase-detector polarity. The feedback register holds the A swallow count, the B main count and a power-down bit.

The decoded fields are held as steady levels for the divider logic. Power-down does not stop the port from shifting or committing. The outputs are plain control levels rather than a stream, so the block has no valid/ready handshake and applies no back-pressure. The host must keep each data bit steady for several system clocks around its serial clock edge. It must not raise the serial clock and the latch strobe within the same few system clocks.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset, ref_count reads 2 and pd_polarity, a_count, b_count and power_down all read 0.
- R2: Each rising edge of ser_clk shifts ser_data into bit 0 of the 18-bit word, and earlier bits move up one place. The first bit sent ends in bit 17 and the last bit sent, bit 0, is the address.
- R3: A latch with address 0 loads ref_count from word bits [10:1] and pd_polarity from bit 11.
- R4: A latch with address 1 loads a_count from bits [5:1], b_count from bits [15:6] and power_down from bit 16.
- R5: A latch leaves the fields of the register it does not address unchanged.
- R6: A reference count of 0 or 1 is stored as 2, so ref_count always lies between 2 and 1023.
- R7: When more than 18 bits are shifted before a latch, only the last 18 bits count.
- R8: The outputs change only as a result of a ser_le rising edge. Shifting bits alone leaves every output as it was.
- R9: While power_down is 1, words still shift and latch normally, and power_down can be cleared through the port.
- R10: Keeping ser_le high while further bits are shifted commits nothing more until ser_le falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock, asynchronous to clk |
| ser_data | input | 1 | Serial data, sampled on ser_clk rising edge |
| ser_le | input | 1 | Latch strobe, commits on rising edge |
| ref_count | output | 10 | Reference divide count (2 to 1023) |
| pd_polarity | output | 1 | Phase-detector polarity |
| a_count | output | 5 | Swallow (A) count |
| b_count | output | 10 | Main (B) count |
| power_down | output | 1 | Power-down request |

## Verification
The bench checks field placement with asymmetric values. A design that swaps the address sense, shifts LSB first or misplaces a field boundary shows a wrong count in the other field. A design that writes both registers is caught because fields of the register that was not addressed drift. Reference counts of 0, 1 and 1023 are sent; a missing clamp shows 0 or 1. Overlong words and outputs sampled part-way through a shift catch designs that latch on a bit count or keep the oldest bits. A held latch strobe catches level-sensitive latching. A word sent while power_down is set catches a port that freezes during power-down.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;
  localparam int WORD_W   = 18;
  localparam int R_W      = 10;
  localparam int A_W      = 5;
  localparam int B_W      = 10;
  localparam int ADDR_BIT = 0;
  localparam int R_LSB    = 1;
  localparam int POL_BIT  = R_LSB + R_W;
  localparam int A_LSB    = 1;
  localparam int B_LSB    = A_LSB + A_W;
  localparam int PD_BIT   = B_LSB + B_W;
  localparam int R_MIN    = 2;

  typedef struct packed {
    logic [R_W-1:0] rcount;
    logic           pol;
  } ref_reg_t;

  typedef struct packed {
    logic [A_W-1:0] acount;
    logic [B_W-1:0] bcount;
    logic           pdown;
  } fb_reg_t;
endpackage

// File: rtl/cfg_sync_edge.sv
module cfg_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= async_i;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[i] <= 1'b0;
      else        chain_q[i] <= chain_q[i-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter
  import cfg_serial_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word_o <= '0;
    else if (shift_en) word_o <= {word_o[WORD_W-2:0], bit_i};
  end

  assert_shift_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (word_o[0] == $past(bit_i)) &&
                 (word_o[WORD_W-1:1] == $past(word_o[WORD_W-2:0])));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(word_o));
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_serial_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [WORD_W-1:0] word_i,
  output ref_reg_t          ref_o,
  output fb_reg_t           fb_o
);
  logic [R_W-1:0] r_raw;
  logic [R_W-1:0] r_clamped;
  logic           sel_fb;
  logic           unused_msb;

  assign r_raw      = word_i[R_LSB +: R_W];
  assign r_clamped  = (r_raw < R_W'(R_MIN)) ? R_W'(R_MIN) : r_raw;
  assign sel_fb     = word_i[ADDR_BIT];
  assign unused_msb = word_i[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_o.rcount <= R_W'(R_MIN);
      ref_o.pol    <= 1'b0;
    end else if (commit_i && !sel_fb) begin
      ref_o.rcount <= r_clamped;
      ref_o.pol    <= word_i[POL_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_o <= '0;
    end else if (commit_i && sel_fb) begin
      fb_o.acount <= word_i[A_LSB +: A_W];
      fb_o.bcount <= word_i[B_LSB +: B_W];
      fb_o.pdown  <= word_i[PD_BIT];
    end
  end

  assert_ref_untouched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && word_i[ADDR_BIT]) |=> $stable(ref_o));

  assert_fb_untouched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !word_i[ADDR_BIT]) |=> $stable(fb_o));

  assert_rcount_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_o.rcount >= R_W'(R_MIN));
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_serial_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_le,
  output logic [R_W-1:0] ref_count,
  output logic           pd_polarity,
  output logic [A_W-1:0] a_count,
  output logic [B_W-1:0] b_count,
  output logic           power_down
);
  logic              sclk_lvl, sclk_rise;
  logic              data_lvl, unused_data_rise;
  logic              le_lvl, le_rise;
  logic [WORD_W-1:0] word;
  ref_reg_t          ref_q;
  fb_reg_t           fb_q;
  logic              unused_lvls;

  assign unused_lvls = sclk_lvl ^ le_lvl;

  cfg_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .async_i(ser_clk),
    .level_o(sclk_lvl), .rise_o(sclk_rise));

  cfg_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_data (
    .clk(clk), .rst_n(rst_n), .async_i(ser_data),
    .level_o(data_lvl), .rise_o(unused_data_rise));

  cfg_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_le (
    .clk(clk), .rst_n(rst_n), .async_i(ser_le),
    .level_o(le_lvl), .rise_o(le_rise));

  cfg_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(sclk_rise),
    .bit_i(data_lvl), .word_o(word));

  cfg_regbank u_regs (
    .clk(clk), .rst_n(rst_n), .commit_i(le_rise),
    .word_i(word), .ref_o(ref_q), .fb_o(fb_q));

  assign ref_count   = ref_q.rcount;
  assign pd_polarity = ref_q.pol;
  assign a_count     = fb_q.acount;
  assign b_count     = fb_q.bcount;
  assign power_down  = fb_q.pdown;

  assert_outputs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !le_rise |=> $stable({ref_count, pd_polarity, a_count, b_count, power_down}));

  assert_commit_while_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && power_down && word[ADDR_BIT]) |=> (power_down == $past(word[PD_BIT])));
endmodule

// File: tb/cfg_serial_port_tb.sv
module cfg_serial_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic [9:0] ref_count;
  logic       pd_polarity;
  logic [4:0] a_count;
  logic [9:0] b_count;
  logic       power_down;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  typedef struct packed {
    logic [9:0] r;
    logic       pol;
    logic [4:0] a;
    logic [9:0] b;
    logic       pd;
  } exp_t;

  exp_t exp_q[$];
  exp_t model;
  event cmp_ev;
  string cmp_tag;

  always #4 clk = ~clk;

  cfg_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_le(ser_le), .ref_count(ref_count), .pd_polarity(pd_polarity),
    .a_count(a_count), .b_count(b_count), .power_down(power_down));

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic exp_t snap();
    exp_t s;
    s.r = ref_count; s.pol = pd_polarity; s.a = a_count;
    s.b = b_count; s.pd = power_down;
    return s;
  endfunction

  // monitor: pops the expected state and compares every output field
  initial begin
    forever begin
      @(cmp_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        exp_t g;
        e = exp_q.pop_front();
        g = snap();
        check(g.r == e.r,     {cmp_tag, " ref_count"},   int'(g.r),   int'(e.r));
        check(g.pol == e.pol, {cmp_tag, " pd_polarity"}, int'(g.pol), int'(e.pol));
        check(g.a == e.a,     {cmp_tag, " a_count"},     int'(g.a),   int'(e.a));
        check(g.b == e.b,     {cmp_tag, " b_count"},     int'(g.b),   int'(e.b));
        check(g.pd == e.pd,   {cmp_tag, " power_down"},  int'(g.pd),  int'(e.pd));
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_data = b;
    wait_clk(4);
    ser_clk = 1'b1;
    wait_clk(4);
    ser_clk = 1'b0;
    wait_clk(4);
  endtask

  task automatic send_word(input logic [17:0] w);
    for (int i = 17; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_le();
    ser_le = 1'b1;
    wait_clk(6);
    ser_le = 1'b0;
    wait_clk(4);
  endtask

  task automatic expect_now(input string tag);
    exp_q.push_back(model);
    cmp_tag = tag;
    ->cmp_ev;
    wait_clk(1);
  endtask

  task automatic write_ref(input logic [9:0] r, input logic pol, input string tag);
    send_word({6'b0, pol, r, 1'b0});
    pulse_le();
    model.r = (r < 10'd2) ? 10'd2 : r;
    model.pol = pol;
    expect_now(tag);
  endtask

  task automatic write_fb(input logic [4:0] a, input logic [9:0] b, input logic pd,
                          input string tag);
    send_word({1'b0, pd, b, a, 1'b1});
    pulse_le();
    model.a = a; model.b = b; model.pd = pd;
    expect_now(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    model = '{r: 10'd2, pol: 1'b0, a: 5'd0, b: 10'd0, pd: 1'b0};
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    expect_now("R1 reset");

    write_ref(10'd300, 1'b1, "R3 R2 ref write");
    write_fb(5'd17, 10'd700, 1'b0, "R4 R5 fb write");
    write_ref(10'd513, 1'b0, "R5 ref write keeps fb");
    write_fb(5'd3, 10'd85, 1'b0, "R4 second fb pattern");
    write_ref(10'd0, 1'b1, "R6 clamp zero");
    write_ref(10'd1, 1'b0, "R6 clamp one");
    write_ref(10'd1023, 1'b1, "R6 top value");

    // R8: outputs steady part-way through a shift
    begin
      logic [17:0] w;
      w = {1'b0, 1'b1, 10'd999, 5'd31, 1'b1};
      for (int i = 17; i >= 9; i--) send_bit(w[i]);
      expect_now("R8 mid-shift");
      for (int i = 8; i >= 0; i--) send_bit(w[i]);
      expect_now("R8 full word unlatched");
      pulse_le();
      model.a = 5'd31; model.b = 10'd999; model.pd = 1'b1;
      expect_now("R8 R4 latched");
    end

    // R9: port still works while powered down
    write_ref(10'd77, 1'b0, "R9 ref during power-down");
    write_fb(5'd9, 10'd400, 1'b0, "R9 clear power-down");

    // R7: overlong shift keeps the last 18 bits
    begin
      logic [17:0] w;
      w = {6'b0, 1'b1, 10'd618, 1'b0};
      for (int i = 0; i < 7; i++) send_bit(1'b1);
      send_word(w);
      pulse_le();
      model.r = 10'd618; model.pol = 1'b1;
      expect_now("R7 overlong word");
    end

    // R10: held strobe does not recommit
    begin
      send_word({1'b0, 1'b0, 10'd12, 5'd4, 1'b1});
      ser_le = 1'b1;
      wait_clk(6);
      model.a = 5'd4; model.b = 10'd12; model.pd = 1'b0;
      expect_now("R10 first commit");
      send_word({6'b0, 1'b0, 10'd200, 1'b0});
      expect_now("R10 held strobe");
      ser_le = 1'b0;
      wait_clk(4);
      pulse_le();
      model.r = 10'd200; model.pol = 1'b0;
      expect_now("R10 new edge commits");
    end

    wait_clk(4);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule